// File: doc/BRIEF.md
# Prioritized Chip-Select Window Decoder

This block decides which of eight external chip selects a bus access belongs to. Each select owns an address window, given as a base address and a power-of-two size. The block compares the access address against every enabled window. A further boot window, whose range comes from reset-time configuration pins, lets the first instruction fetch after reset reach the boot device. The boot window drives the same output line as select 0.

When windows overlap, a fixed rule resolves the conflict: the lowest-numbered select wins, and the boot window ranks with select 0. The result is registered when a transfer-start strobe arrives. It is presented as active-low selects, the winning index, a hit flag, and a miss pulse. A downstream bus sequencer uses these outputs. A simple write port loads each window's base, size and enable. The same port can switch the boot window on or off.

Top module: `csw_decoder`

## Requirements
- R1: While `rst` is high and in the first cycle after it, every `cs_n` bit is 1, and `hit`, `miss` and `sel_idx` are 0. After reset the boot window is enabled and windows 0 to 7 are disabled.
- R2: The boot window's base and log2 size are taken from `boot_base` and `boot_lg2` on each clock edge where `rst` is high. An access inside the boot window drives `cs_n[0]` low with `sel_idx` = 0.
- R3: An enabled window with base B and size field L matches address A exactly when B <= A < B + 2^L, for L from 0 to 32.
- R4: When several enabled windows match, the lowest-numbered select wins. The boot window counts as select 0.
- R5: At most one bit of `cs_n` is 0 in any cycle.
- R6: A strobed access that matches no enabled window sets every `cs_n` bit to 1 and `hit` to 0, and `sel_idx` to 0. It also raises `miss` for exactly one cycle.
- R7: The outputs are updated on the clock edge where `ts` is high, using that cycle's `addr` and the configuration held before that edge. Without `ts`, `cs_n`, `hit` and `sel_idx` hold their values and `miss` is 0.
- R8: A write with `cfg_we` high and `cfg_idx` from 0 to 7 loads that window's base, size and enable from `cfg_base`, `cfg_lg2` and `cfg_en`. The new values take effect for strobes from the next cycle on.
- R9: A write with `cfg_idx` = 8 sets only the boot window's enable from `cfg_en`. The boot base and size are unchanged. Writes with `cfg_idx` from 9 to 15 change nothing.
- R10: A disabled window never selects, even when the address lies inside its range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_base | input | 32 | Boot window base, sampled during reset |
| boot_lg2 | input | 6 | Boot window log2 size, sampled during reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Window to write: 0-7 general, 8 boot enable |
| cfg_base | input | 32 | Window base to write |
| cfg_lg2 | input | 6 | Window log2 size to write |
| cfg_en | input | 1 | Window enable to write |
| ts | input | 1 | Transfer-start strobe |
| addr | input | 32 | Access address |
| cs_n | output | 8 | Active-low chip selects |
| hit | output | 1 | Last strobed access matched a window |
| sel_idx | output | 3 | Index of the winning select |
| miss | output | 1 | One-cycle pulse on an unmatched access |

## Verification
The bench probes the last byte inside a window and the first byte past it. A design with an off-by-one limit would select one address too many or too few there. It also tests a boot window ending at the top of the address space: a limit computed without a carry bit would wrap to zero and never match. Overlaps between the boot window and a lower-priority window, and between two general windows, expose a priority encoder that lets the wrong select win or asserts two selects. Writes to the boot-enable slot and to unused slots check that the boot range is never overwritten. Strobes in the same cycle as a write check that the old configuration is used. Idle cycles between strobes check that a design does not refresh its outputs without `ts`, and does not let `miss` linger.

// File: rtl/csw_pkg.sv
package csw_pkg;
    parameter int ADDR_W    = 32;
    parameter int NUM_CS    = 8;
    localparam int LG_W      = $clog2(ADDR_W + 1);
    localparam int IDX_W     = $clog2(NUM_CS);
    localparam int CFG_IDX_W = IDX_W + 1;
    localparam int BOOT_SLOT = NUM_CS;

    typedef struct packed {
        logic              en;
        logic [LG_W-1:0]   lg2;
        logic [ADDR_W-1:0] base;
    } win_t;

    // base <= a < base + 2**lg2, limit computed one bit wider
    function automatic logic in_window(input logic [ADDR_W-1:0] a, input win_t w);
        logic [ADDR_W:0] span;
        logic [ADDR_W:0] limit;
        span  = {{ADDR_W{1'b0}}, 1'b1} << w.lg2;
        limit = {1'b0, w.base} + span;
        return w.en && (a >= w.base) && ({1'b0, a} < limit);
    endfunction
endpackage

// File: rtl/csw_regs.sv
module csw_regs
    import csw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    boot_base,
    input  logic [LG_W-1:0]      boot_lg2,
    input  logic                 cfg_we,
    input  logic [CFG_IDX_W-1:0] cfg_idx,
    input  logic [ADDR_W-1:0]    cfg_base,
    input  logic [LG_W-1:0]      cfg_lg2,
    input  logic                 cfg_en,
    output win_t [NUM_CS-1:0]    wins,
    output win_t                 boot
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                wins[i] <= '0;
            end else if (cfg_we && cfg_idx == CFG_IDX_W'(i)) begin
                wins[i].en   <= cfg_en;
                wins[i].lg2  <= cfg_lg2;
                wins[i].base <= cfg_base;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            boot.en   <= 1'b1;
            boot.lg2  <= boot_lg2;
            boot.base <= boot_base;
        end else if (cfg_we && cfg_idx == CFG_IDX_W'(BOOT_SLOT)) begin
            boot.en <= cfg_en;
        end
    end

    logic [NUM_CS-1:0] en_vec;
    always_comb begin
        for (int i = 0; i < NUM_CS; i++) en_vec[i] = wins[i].en;
    end

    // R1: only the boot window is live when reset ends
    a_r1_boot_only: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (boot.en && en_vec == '0));
    // R9: boot range never changes outside reset
    a_r9_boot_range_kept: assert property (@(posedge clk) disable iff (rst)
        !$fell(rst) |-> ($stable(boot.base) && $stable(boot.lg2)));
endmodule

// File: rtl/csw_match.sv
module csw_match
    import csw_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  win_t [NUM_CS-1:0] wins,
    input  win_t              boot,
    output logic [NUM_CS-1:0] hits
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cmp
        if (i == 0) begin : g_shared
            assign hits[i] = in_window(addr, wins[i]) || in_window(addr, boot);
        end else begin : g_plain
            assign hits[i] = in_window(addr, wins[i]);
        end
    end
endmodule

// File: rtl/csw_prio.sv
module csw_prio
    import csw_pkg::*;
(
    input  logic [NUM_CS-1:0] hits,
    output logic              any,
    output logic [IDX_W-1:0]  idx,
    output logic [NUM_CS-1:0] onehot
);
    always_comb begin
        idx    = '0;
        onehot = '0;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (hits[i]) begin
                idx    = IDX_W'(i);
                onehot = NUM_CS'(1) << i;
            end
        end
        any = |hits;
    end
endmodule

// File: rtl/csw_decoder.sv
module csw_decoder
    import csw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    boot_base,
    input  logic [LG_W-1:0]      boot_lg2,
    input  logic                 cfg_we,
    input  logic [CFG_IDX_W-1:0] cfg_idx,
    input  logic [ADDR_W-1:0]    cfg_base,
    input  logic [LG_W-1:0]      cfg_lg2,
    input  logic                 cfg_en,
    input  logic                 ts,
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_CS-1:0]    cs_n,
    output logic                 hit,
    output logic [IDX_W-1:0]     sel_idx,
    output logic                 miss
);
    win_t [NUM_CS-1:0] wins;
    win_t              boot;
    logic [NUM_CS-1:0] hits;
    logic              any;
    logic [IDX_W-1:0]  win_idx;
    logic [NUM_CS-1:0] onehot;

    csw_regs u_regs (
        .clk(clk), .rst(rst), .boot_base(boot_base), .boot_lg2(boot_lg2),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
        .cfg_lg2(cfg_lg2), .cfg_en(cfg_en), .wins(wins), .boot(boot)
    );

    csw_match u_match (.addr(addr), .wins(wins), .boot(boot), .hits(hits));

    csw_prio u_prio (.hits(hits), .any(any), .idx(win_idx), .onehot(onehot));

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n    <= '1;
            hit     <= 1'b0;
            sel_idx <= '0;
            miss    <= 1'b0;
        end else if (ts) begin
            cs_n    <= ~onehot;
            hit     <= any;
            sel_idx <= any ? win_idx : '0;
            miss    <= ~any;
        end else begin
            miss    <= 1'b0;
        end
    end

    // R5: never two selects at once
    a_r5_single_select: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n) <= 1);
    // R6: a miss leaves all selects idle
    a_r6_miss_idle: assert property (@(posedge clk) disable iff (rst)
        miss |-> (&cs_n && !hit));
    // R7: no strobe, no change
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !ts |=> ($stable(cs_n) && $stable(sel_idx) && !miss));
    // R4: a match on slot 0 always wins
    a_r4_slot0_wins: assert property (@(posedge clk) disable iff (rst)
        (ts && hits[0]) |=> (!cs_n[0] && sel_idx == '0));
endmodule

// File: tb/test_csw_decoder.sv
module test_csw_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] boot_base = 32'hFFF0_0000;
    logic [5:0]  boot_lg2  = 6'd20;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_base = '0;
    logic [5:0]  cfg_lg2 = '0;
    logic        cfg_en = 1'b0;
    logic        ts = 1'b0;
    logic [31:0] addr = '0;
    logic [7:0]  cs_n;
    logic        hit;
    logic [2:0]  sel_idx;
    logic        miss;

    always #10 clk = ~clk;

    csw_decoder i_csw_decoder (
        .clk(clk), .rst(rst), .boot_base(boot_base), .boot_lg2(boot_lg2),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
        .cfg_lg2(cfg_lg2), .cfg_en(cfg_en), .ts(ts), .addr(addr),
        .cs_n(cs_n), .hit(hit), .sel_idx(sel_idx), .miss(miss)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R1";

    longint m_base[8];
    int     m_lg[8];
    bit     m_en[8];
    longint b_base;
    int     b_lg;
    bit     b_en;
    logic [7:0] e_cs_n = '1;
    bit         e_hit = 0;
    int         e_idx = 0;
    bit         e_miss = 0;

    function automatic bit inside_w(longint a, longint b, int lg, bit en);
        return en && a >= b && a < b + (64'd1 << lg);
    endfunction

    task automatic model_edge();
        if (rst) begin
            for (int i = 0; i < 8; i++) begin m_base[i] = 0; m_lg[i] = 0; m_en[i] = 0; end
            b_base = longint'(boot_base); b_lg = int'(boot_lg2); b_en = 1;
            e_cs_n = '1; e_hit = 0; e_idx = 0; e_miss = 0;
        end else begin
            if (ts) begin
                int w;
                w = -1;
                for (int i = 7; i >= 0; i--) begin
                    if (inside_w(longint'(addr), m_base[i], m_lg[i], m_en[i])) w = i;
                    if (i == 0 && inside_w(longint'(addr), b_base, b_lg, b_en)) w = 0;
                end
                if (w < 0) begin e_cs_n = '1; e_hit = 0; e_idx = 0; e_miss = 1; end
                else begin e_cs_n = ~(8'd1 << w); e_hit = 1; e_idx = w; e_miss = 0; end
            end else begin
                e_miss = 0;
            end
            if (cfg_we) begin
                if (cfg_idx < 8) begin
                    m_base[cfg_idx] = longint'(cfg_base);
                    m_lg[cfg_idx] = int'(cfg_lg2);
                    m_en[cfg_idx] = cfg_en;
                end else if (cfg_idx == 8) begin
                    b_en = cfg_en;
                end
            end
        end
    endtask

    task automatic compare();
        checks++;
        if (cs_n !== e_cs_n || hit !== e_hit || int'(sel_idx) != e_idx || miss !== e_miss) begin
            errors++;
            $display("FAIL %s cs_n=%b hit=%b idx=%0d miss=%b expected cs_n=%b hit=%b idx=%0d miss=%b",
                     tag, cs_n, hit, sel_idx, miss, e_cs_n, e_hit, e_idx, e_miss);
        end
        checks++;
        if ($countones(~cs_n) > 1) begin
            errors++;
            $display("FAIL R5 cs_n=%b expected at most one low bit", cs_n);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        cfg_we = 0;
        ts = 0;
    endtask

    task automatic access(input logic [31:0] a);
        ts = 1; addr = a; cyc();
    endtask

    task automatic wr(input int idx, input logic [31:0] b, input int lg, input bit en);
        cfg_we = 1; cfg_idx = 4'(idx); cfg_base = b; cfg_lg2 = 6'(lg); cfg_en = en; cyc();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        tag = "R1";
        repeat (3) cyc();
        rst = 0;
        boot_base = 32'h0; boot_lg2 = 6'd0;
        cyc(); cyc();

        tag = "R2";
        access(32'hFFF0_0010);
        access(32'hFFFF_FFFF);
        tag = "R6";
        access(32'hFFEF_FFFF);
        cyc();

        tag = "R8";
        wr(3, 32'h1000_0000, 16, 1);
        wr(5, 32'h1000_0000, 20, 1);
        cfg_we = 1; cfg_idx = 4'd7; cfg_base = 32'h2000_0000; cfg_lg2 = 6'd12; cfg_en = 1;
        ts = 1; addr = 32'h2000_0000; cyc();
        access(32'h2000_0000);

        tag = "R3";
        access(32'h1000_FFFF);
        access(32'h1001_0000);
        access(32'h100F_FFFF);
        access(32'h1010_0000);
        access(32'h0FFF_FFFF);
        access(32'h2000_0FFF);
        access(32'h2000_1000);

        tag = "R4";
        wr(1, 32'h1000_0000, 8, 1);
        access(32'h1000_0000);
        access(32'h1000_0100);
        wr(2, 32'hFF00_0000, 24, 1);
        access(32'hFFF0_0000);
        access(32'hFF00_0000);

        tag = "R7";
        addr = 32'h1000_0000; cyc();
        addr = 32'h0000_0000; cyc();
        addr = 32'hFFF0_0000; cyc();
        access(32'h0000_0004);
        addr = 32'h1000_0000; cyc();

        tag = "R9";
        wr(8, 32'h1234_5678, 3, 0);
        access(32'hFFF0_0000);
        wr(12, 32'h0000_0000, 31, 1);
        access(32'h0000_0000);
        wr(8, 32'h0000_0000, 31, 1);
        access(32'hFFF0_0000);
        access(32'h0000_0000);

        tag = "R10";
        wr(3, 32'h1000_0000, 16, 0);
        access(32'h1000_FFFF);
        wr(7, 32'h2000_0000, 12, 0);
        access(32'h2000_0004);
        cyc();

        finish_run();
    end
endmodule